// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

This block shifts or rotates one operand of 8, 16 or 32 bits by a variable count and produces the new value together with carry, parity, zero, sign and overflow flags. It offers seven distinct operations: left shift, logical right shift, arithmetic right shift, rotate left, rotate right, and rotate left or right through the carry bit. A flag write mask tells the flag register which flags the operation updates.

The datapath is combinational and ends in a single output register, so a request presented with `in_valid_i` high appears on the outputs one clock later. Every supported width is built as its own lane. The size code selects one lane's result, and the count is reduced to its low five bits before use. A count of zero passes the operand through and writes no flag.

Top module: `sru_top`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` delayed by one clock, and the results of a request appear in that same cycle. While `rst_ni` is low every output reads zero.
- R2: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected width are ignored, and result bits above it read zero.
- R3: Only bits [4:0] of `count_i` are used. When those bits are zero, the result equals the sized operand and `flags_we_o` is zero.
- R4: Operation codes 0 and 7 both perform a left shift. Bit 0 is filled with zero and the carry receives the last bit pushed out of the top. A count larger than the width gives a result of zero and a carry of zero.
- R5: Operation code 1 is a logical right shift. The top bit is filled with zero and the carry receives the last bit pushed out of bit 0.
- R6: Operation code 2 is an arithmetic right shift. The sign bit is replicated, and a count at or above the width gives all sign bits with the carry equal to the sign.
- R7: Operation code 3 rotates left and code 4 rotates right, each by the count modulo the width. After a left rotate the carry equals result bit 0. After a right rotate it equals the result's top bit.
- R8: Operation code 5 rotates left and code 6 rotates right through a ring of width+1 bits, with `carry_i` as the bit above the operand. The rotate amount is the count modulo width+1, and the carry output is the ring's extra bit afterwards.
- R9: The flag vector uses bit 0 for carry, bit 1 for parity, bit 2 for zero, bit 3 for sign and bit 4 for overflow. For a shift with a nonzero count all five bits of `flags_we_o` are set. Zero means the sized result is 0, sign is the result's top bit, and parity is 1 when the low result byte has an even number of ones.
- R10: For a rotate with a nonzero count, `flags_we_o` is 5'b10001. Any flag whose write bit is clear reads zero.
- R11: Overflow equals the result's top bit XOR the new carry for codes 0, 3, 5 and 7. For code 1 it equals the original top bit, and for code 2 it is zero. For codes 4 and 6 it equals the XOR of the result's two top bits.
- R12: In a cycle where `out_valid_o` is low, `flags_we_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| operand_i | input | DATA_W (32) | Value to shift or rotate |
| size_i | input | 2 | Operand size code |
| op_i | input | 3 | Operation code |
| count_i | input | CNT_W (8) | Shift or rotate count, low five bits used |
| carry_i | input | 1 | Incoming carry flag |
| out_valid_o | output | 1 | Result valid |
| result_o | output | DATA_W (32) | Shifted or rotated value |
| flags_o | output | 5 | New flag values {overflow, sign, zero, parity, carry} |
| flags_we_o | output | 5 | Per-flag write enable, same bit order |

## Verification
The bench covers counts that exceed the operand width. A shifter that wraps the count there would return a non-zero value or a stale carry. It covers 8-bit rotates through carry with counts of 9 and above, where using the width as the modulus instead of width+1 corrupts the ring. It covers masked counts such as 32, which must behave like zero, so a design that kept the sixth bit would write flags it should leave alone. It also covers narrow sizes with junk in the upper operand bits, negative values under the arithmetic shift, and the alias code 7. A wrong sign fill, a leak from upper bits or a missing alias each shows up as a result or flag mismatch against the bench's bit-by-bit model.

// File: rtl/sru_pkg.sv
package sru_pkg;

   typedef enum logic [2:0] {
      OP_SHL = 3'd0,
      OP_SHR = 3'd1,
      OP_SAR = 3'd2,
      OP_ROL = 3'd3,
      OP_ROR = 3'd4,
      OP_RCL = 3'd5,
      OP_RCR = 3'd6,
      OP_SAL = 3'd7
   } sru_op_e;

   localparam int NUM_FLAGS = 5;
   localparam int FL_CY  = 0;
   localparam int FL_PAR = 1;
   localparam int FL_ZRO = 2;
   localparam int FL_SGN = 3;
   localparam int FL_OVF = 4;

   function automatic logic is_rotate(sru_op_e op);
      return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
   endfunction

endpackage

// File: rtl/sru_lane.sv
module sru_lane
   import sru_pkg::*;
#(
   parameter int W     = 8,
   parameter int CNT_L = 5
) (
   input  logic [W-1:0]     a_i,
   input  sru_op_e          op_i,
   input  logic [CNT_L-1:0] n_i,
   input  logic             cin_i,
   output logic [W-1:0]     res_o,
   output logic             cy_o,
   output logic             ovf_o
);

   localparam int RW  = $clog2(W);
   localparam int RCW = $clog2(W + 2);
   localparam int XW  = W + (1 << CNT_L);

   logic [XW-1:0]      shl_x;
   logic [W:0]         shr_x;
   logic signed [W:0]  sar_x;
   logic [2*W-1:0]     rol_x;
   logic [2*W-1:0]     ror_x;
   logic [2*W+1:0]     rcl_x;
   logic [2*W+1:0]     rcr_x;
   logic [W:0]         ring;
   logic [RW-1:0]      rot_n;
   logic [RCW-1:0]     rc_n;

   always_comb begin
      rot_n = n_i[RW-1:0];
      rc_n  = RCW'(32'(n_i) % (W + 1));
      ring  = {cin_i, a_i};
      shl_x = {{(1 << CNT_L){1'b0}}, a_i} << n_i;
      shr_x = {a_i, 1'b0} >> n_i;
      sar_x = $signed({a_i, 1'b0}) >>> n_i;
      rol_x = {a_i, a_i} << rot_n;
      ror_x = {a_i, a_i} >> rot_n;
      rcl_x = {ring, ring} << rc_n;
      rcr_x = {ring, ring} >> rc_n;

      res_o = a_i;
      cy_o  = cin_i;
      ovf_o = 1'b0;
      unique case (op_i)
         OP_SHL, OP_SAL: begin
            res_o = shl_x[W-1:0];
            cy_o  = shl_x[W];
            ovf_o = res_o[W-1] ^ cy_o;
         end
         OP_SHR: begin
            res_o = shr_x[W:1];
            cy_o  = shr_x[0];
            ovf_o = a_i[W-1];
         end
         OP_SAR: begin
            res_o = sar_x[W:1];
            cy_o  = sar_x[0];
            ovf_o = 1'b0;
         end
         OP_ROL: begin
            res_o = rol_x[2*W-1:W];
            cy_o  = res_o[0];
            ovf_o = res_o[W-1] ^ cy_o;
         end
         OP_ROR: begin
            res_o = ror_x[W-1:0];
            cy_o  = res_o[W-1];
            ovf_o = res_o[W-1] ^ res_o[W-2];
         end
         OP_RCL: begin
            res_o = rcl_x[2*W:W+1];
            cy_o  = rcl_x[2*W+1];
            ovf_o = res_o[W-1] ^ cy_o;
         end
         OP_RCR: begin
            res_o = rcr_x[W-1:0];
            cy_o  = rcr_x[W];
            ovf_o = res_o[W-1] ^ res_o[W-2];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sru_flags.sv
module sru_flags
   import sru_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]    res_i,
   input  logic                 sign_i,
   input  logic                 cy_i,
   input  logic                 ovf_i,
   input  sru_op_e              op_i,
   input  logic                 cnt_zero_i,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic [NUM_FLAGS-1:0] we_o
);

   logic [NUM_FLAGS-1:0] raw;

   always_comb begin
      raw         = '0;
      raw[FL_CY]  = cy_i;
      raw[FL_PAR] = ~^res_i[7:0];
      raw[FL_ZRO] = (res_i == '0);
      raw[FL_SGN] = sign_i;
      raw[FL_OVF] = ovf_i;

      if (cnt_zero_i) begin
         we_o = '0;
      end else if (is_rotate(op_i)) begin
         we_o         = '0;
         we_o[FL_CY]  = 1'b1;
         we_o[FL_OVF] = 1'b1;
      end else begin
         we_o = '1;
      end
      flags_o = raw & we_o;
   end

endmodule

// File: rtl/sru_top.sv
module sru_top
   import sru_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 in_valid_i,
   input  logic [DATA_W-1:0]    operand_i,
   input  logic [1:0]           size_i,
   input  logic [2:0]           op_i,
   input  logic [CNT_W-1:0]     count_i,
   input  logic                 carry_i,
   output logic                 out_valid_o,
   output logic [DATA_W-1:0]    result_o,
   output logic [4:0]           flags_o,
   output logic [4:0]           flags_we_o
);

   localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;
   localparam int CNT_L     = 5;

   if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_width
      $error("sru_top: DATA_W must be 8, 16, 32 or 64");
   end
   if (CNT_W < CNT_L) begin : g_bad_cnt
      $error("sru_top: CNT_W must cover the five used count bits");
   end
   if (NUM_FLAGS != 5) begin : g_bad_flags
      $error("sru_top: flag vector width mismatch");
   end

   sru_op_e             op;
   logic [CNT_L-1:0]    n_used;
   logic                cnt_zero;
   logic [1:0]          sel;
   logic [CNT_W-1:0]    cnt_unused;

   logic [DATA_W-1:0]   lane_res [NUM_LANES];
   logic                lane_cy  [NUM_LANES];
   logic                lane_ovf [NUM_LANES];
   logic                lane_msb [NUM_LANES];

   logic [DATA_W-1:0]   sel_res;
   logic [4:0]          flg;
   logic [4:0]          flg_we;

   assign op         = sru_op_e'(op_i);
   assign n_used     = count_i[CNT_L-1:0];
   assign cnt_zero   = (n_used == '0);
   assign cnt_unused = count_i;
   assign sel        = (int'(size_i) >= NUM_LANES) ? 2'(NUM_LANES - 1) : size_i;

   for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
      localparam int LW = 8 << gi;
      logic [LW-1:0] l_res;
      logic          l_cy;
      logic          l_ovf;

      sru_lane #(
         .W     (LW),
         .CNT_L (CNT_L)
      ) lane_i (
         .a_i   (operand_i[LW-1:0]),
         .op_i  (op),
         .n_i   (n_used),
         .cin_i (carry_i),
         .res_o (l_res),
         .cy_o  (l_cy),
         .ovf_o (l_ovf)
      );

      assign lane_res[gi] = cnt_zero ? DATA_W'(operand_i[LW-1:0]) : DATA_W'(l_res);
      assign lane_cy[gi]  = l_cy;
      assign lane_ovf[gi] = l_ovf;
      assign lane_msb[gi] = lane_res[gi][LW-1];
   end

   assign sel_res = lane_res[sel];

   sru_flags #(
      .DATA_W (DATA_W)
   ) flags_i (
      .res_i      (sel_res),
      .sign_i     (lane_msb[sel]),
      .cy_i       (lane_cy[sel]),
      .ovf_i      (lane_ovf[sel]),
      .op_i       (op),
      .cnt_zero_i (cnt_zero),
      .flags_o    (flg),
      .we_o       (flg_we)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         result_o    <= '0;
         flags_o     <= '0;
         flags_we_o  <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            result_o <= sel_res;
         end
         flags_o    <= in_valid_i ? flg    : '0;
         flags_we_o <= in_valid_i ? flg_we : '0;
      end
   end

endmodule

// File: rtl/sru_chk.sv
module sru_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              in_valid_i,
   input logic [1:0]        size_i,
   input logic [2:0]        op_i,
   input logic [CNT_W-1:0]  count_i,
   input logic              out_valid_o,
   input logic [DATA_W-1:0] result_o,
   input logic [4:0]        flags_o,
   input logic [4:0]        flags_we_o
);

   p_valid_pipe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (out_valid_o == $past(in_valid_i)));

   p_narrow_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(in_valid_i) && $past(size_i) == 2'd0) |-> ((result_o >> 8) == '0));

   p_zero_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(in_valid_i) && $past(count_i[4:0]) == 5'd0) |-> (flags_we_o == 5'd0));

   p_zero_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_we_o[2] |-> (flags_o[2] == (result_o == '0)));

   p_rot_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(in_valid_i) && $past(op_i) >= 3'd3 && $past(op_i) <= 3'd6)
         |-> (flags_we_o[3:1] == 3'b000));

   p_unwritten_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flags_o & ~flags_we_o) == 5'd0));

   p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(in_valid_i) && $past(op_i) == 3'd2) |-> !flags_o[4]);

   p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_valid_o |-> (flags_we_o == 5'd0 && flags_o == 5'd0));

endmodule

bind sru_top sru_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid_i  (in_valid_i),
   .size_i      (size_i),
   .op_i        (op_i),
   .count_i     (count_i),
   .out_valid_o (out_valid_o),
   .result_o    (result_o),
   .flags_o     (flags_o),
   .flags_we_o  (flags_we_o)
);

// File: tb/sru_top_tb_top.sv
`timescale 1ns/1ps
module sru_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [1:0]  size = '0;
   logic [2:0]  op = '0;
   logic [7:0]  count = '0;
   logic        carry = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic [4:0]  flags;
   logic [4:0]  flags_we;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   logic        exp_valid = 1'b0;
   logic [31:0] exp_res;
   logic [4:0]  exp_flags;
   logic [4:0]  exp_we;
   string       tag_res, tag_flg, tag_we;

   always #4 clk = ~clk;

   sru_top dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .in_valid_i  (in_valid),
      .operand_i   (operand),
      .size_i      (size),
      .op_i        (op),
      .count_i     (count),
      .carry_i     (carry),
      .out_valid_o (out_valid),
      .result_o    (result),
      .flags_o     (flags),
      .flags_we_o  (flags_we)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Behavioural model: repeated one-bit steps
   task automatic model(input logic [2:0] m_op, input logic [1:0] m_sz, input logic [31:0] a,
                        input logic [7:0] cnt, input logic cin,
                        output logic [31:0] r, output logic [4:0] f, output logic [4:0] we);
      int w, n;
      logic c, top0, ov, ob;
      logic [31:0] v, msk;
      w    = (m_sz == 2'd0) ? 8 : (m_sz == 2'd1) ? 16 : 32;
      msk  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
      v    = a & msk;
      n    = int'(cnt) & 31;
      c    = cin;
      top0 = v[w-1];
      r = v; f = '0; we = '0;
      if (n != 0) begin
         for (int i = 0; i < n; i++) begin
            case (m_op)
               3'd0, 3'd7: begin c = v[w-1]; v = (v << 1) & msk; end
               3'd1: begin c = v[0]; v = v >> 1; end
               3'd2: begin c = v[0]; v = v[w-1] ? ((v >> 1) | (32'h1 << (w-1))) : (v >> 1); end
               3'd3: begin ob = v[w-1]; v = ((v << 1) & msk) | {31'b0, ob}; c = ob; end
               3'd4: begin ob = v[0]; v = ob ? ((v >> 1) | (32'h1 << (w-1))) : (v >> 1); c = ob; end
               3'd5: begin ob = v[w-1]; v = ((v << 1) & msk) | {31'b0, c}; c = ob; end
               default: begin ob = v[0]; v = c ? ((v >> 1) | (32'h1 << (w-1))) : (v >> 1); c = ob; end
            endcase
         end
         case (m_op)
            3'd1: ov = top0;
            3'd2: ov = 1'b0;
            3'd4, 3'd6: ov = v[w-1] ^ v[w-2];
            default: ov = v[w-1] ^ c;
         endcase
         r  = v;
         we = (m_op >= 3'd3 && m_op <= 3'd6) ? 5'b10001 : 5'b11111;
         f  = {ov, v[w-1], (v == 32'h0), ~^v[7:0], c} & we;
      end
   endtask

   task automatic check_outputs();
      chk("R1 valid", {31'b0, out_valid}, {31'b0, exp_valid});
      if (exp_valid) begin
         chk(tag_res, result, exp_res);
         chk(tag_flg, {27'b0, flags}, {27'b0, exp_flags});
         chk(tag_we, {27'b0, flags_we}, {27'b0, exp_we});
      end else begin
         chk("R12 idle write", {27'b0, flags_we}, 32'h0);
      end
   endtask

   task automatic drive(input logic [2:0] d_op, input logic [1:0] d_sz, input logic [31:0] a,
                        input logic [7:0] cnt, input logic cin, input logic v);
      @(negedge clk);
      if (!finished) check_outputs();
      in_valid = v; op = d_op; size = d_sz; operand = a; count = cnt; carry = cin;
      model(d_op, d_sz, a, cnt, cin, exp_res, exp_flags, exp_we);
      exp_valid = v;
      if ((cnt & 8'h1F) == 8'h0) tag_res = "R3 zero count";
      else case (d_op)
         3'd0, 3'd7: tag_res = "R4 left shift";
         3'd1:       tag_res = "R5 logical right";
         3'd2:       tag_res = "R6 arithmetic right";
         3'd3, 3'd4: tag_res = "R7 rotate";
         default:    tag_res = "R8 rotate through carry";
      endcase
      if (d_sz == 2'd0 || d_sz == 2'd3) tag_res = {tag_res, " R2 size"};
      tag_flg = (d_op >= 3'd3 && d_op <= 3'd6) ? "R10 R11 rotate flags" : "R9 R11 shift flags";
      tag_we  = ((cnt & 8'h1F) == 8'h0) ? "R3 no write" :
                (d_op >= 3'd3 && d_op <= 3'd6) ? "R10 rotate mask" : "R9 shift mask";
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset valid", {31'b0, out_valid}, 32'h0);
      chk("R1 reset result", result, 32'h0);
      chk("R1 reset flags", {22'b0, flags, flags_we}, 32'h0);
      rst_n = 1'b1;

      // R4: 6Ah << 3 -> 50h carry set, alias code 7 identical
      drive(3'd0, 2'd0, 32'h0000_006A, 8'd3, 1'b0, 1'b1);
      drive(3'd7, 2'd0, 32'h0000_006A, 8'd3, 1'b0, 1'b1);
      // R4: counts at and beyond width
      drive(3'd0, 2'd0, 32'h0000_0081, 8'd8, 1'b0, 1'b1);
      drive(3'd0, 2'd0, 32'h0000_00FF, 8'd9, 1'b1, 1'b1);
      // R7: 6Ah rol 1 -> D4h, rol 3 -> 53h, ror
      drive(3'd3, 2'd0, 32'h0000_006A, 8'd1, 1'b0, 1'b1);
      drive(3'd3, 2'd0, 32'h0000_006A, 8'd3, 1'b0, 1'b1);
      drive(3'd4, 2'd0, 32'h0000_0001, 8'd1, 1'b0, 1'b1);
      drive(3'd4, 2'd1, 32'h0000_1234, 8'd16, 1'b0, 1'b1);
      // R5 R11: logical right, overflow = old top bit
      drive(3'd1, 2'd1, 32'h0000_8001, 8'd1, 1'b0, 1'b1);
      drive(3'd1, 2'd2, 32'hF000_0000, 8'd31, 1'b0, 1'b1);
      // R6: negative values, count beyond width
      drive(3'd2, 2'd0, 32'h0000_0085, 8'd1, 1'b0, 1'b1);
      drive(3'd2, 2'd0, 32'h0000_0085, 8'd20, 1'b0, 1'b1);
      drive(3'd2, 2'd2, 32'h8000_0001, 8'd4, 1'b1, 1'b1);
      // R8: ring of width+1
      drive(3'd5, 2'd0, 32'h0000_00A5, 8'd9, 1'b1, 1'b1);
      drive(3'd5, 2'd0, 32'h0000_0080, 8'd1, 1'b0, 1'b1);
      drive(3'd6, 2'd2, 32'h0000_0001, 8'd1, 1'b1, 1'b1);
      drive(3'd6, 2'd1, 32'h0000_0001, 8'd17, 1'b0, 1'b1);
      // R3: masked count and zero count
      drive(3'd0, 2'd2, 32'hDEAD_BEEF, 8'h20, 1'b1, 1'b1);
      drive(3'd0, 2'd2, 32'hDEAD_BEEF, 8'hE3, 1'b1, 1'b1);
      drive(3'd3, 2'd1, 32'h0000_0000, 8'd0, 1'b1, 1'b1);
      // R2: junk above the selected width, size code 3
      drive(3'd1, 2'd0, 32'hFFFF_FF80, 8'd2, 1'b0, 1'b1);
      drive(3'd0, 2'd3, 32'h4000_0000, 8'd1, 1'b0, 1'b1);
      // R9: zero and parity outcome
      drive(3'd1, 2'd0, 32'h0000_0001, 8'd1, 1'b0, 1'b1);
      // R12: idle cycle with live-looking inputs
      drive(3'd0, 2'd2, 32'hFFFF_FFFF, 8'd5, 1'b1, 1'b0);
      drive(3'd3, 2'd0, 32'h0000_00FF, 8'd2, 1'b1, 1'b0);

      for (int k = 0; k < 4000; k++) begin
         logic [7:0] rc;
         rc = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 10));
         drive(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom, rc,
               1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0));
      end
      drive(3'd0, 2'd0, 32'h0, 8'd0, 1'b0, 1'b0);
      @(negedge clk);
      if (!finished) begin
         check_outputs();
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule